// File: doc/BRIEF.md
# Serial-Controlled Stereo Volume Attenuator

This block scales a stream of stereo audio samples by a gain that is set over a slow three-wire control port. The port has a control clock that idles high, a data line, and an active-low load strobe. A host shifts a 14-bit command into the block, least significant bit first. The first eight bits form a fixed key and the last six bits form an attenuation code. When the host then pulls the load strobe low, the block latches the code, but only if the whole command arrived and the key matches. Each control pin passes through a synchronizer into the system clock domain. Bits are taken on rising edges of the synchronized control clock.

Each incoming left/right pair marked valid is multiplied by a 7-bit linear multiplier derived from the latched code. The product is shifted right arithmetically by six bits. The pair appears one cycle later with a valid strobe. Code 0 passes samples unchanged, codes 1 to 62 step the gain down in 1/64 steps, and code 63 mutes. A typical use is as the volume stage ahead of an interpolation filter in an audio playback path.

Top module: `vatt_top`

## Requirements
- R1: After reset, out_valid is 0, both output samples are 0, and the latched code is 0, so the first samples pass through at unity gain.
- R2: A command is taken from rising edges of the control clock while the load strobe is high, least significant bit first. Command bits 7..0 are the key and bits 13..8 are the code, with code bit 0 in command bit 8. The latched code changes only when the load strobe falls.
- R3: A command whose key is not 0x5D is discarded, and the previous code stays in force.
- R4: A load strobe that falls after fewer than 14 bits since the strobe last rose is discarded. If more than 14 bits arrive, the last 14 form the command.
- R5: For a code k from 1 to 62, each output equals floor(sample × (63 − k) / 64).
- R6: Code 0 passes both samples unchanged, including the extreme values −32768 and 32767.
- R7: Code 63 drives both outputs to 0 for any input.
- R8: Negative products round toward negative infinity. For example, −1 at code 62 gives −1, and −65 at code 62 gives −2.
- R9: out_valid is high exactly in the cycle after in_valid was high. While in_valid is low, the output samples hold their last values.
- R10: Left and right are scaled by the same gain, each from its own input sample.
- R11: A reset that follows a latched command restores unity gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_clk | input | 1 | Control port shift clock, idles high |
| ctl_data | input | 1 | Control port serial data |
| ctl_load_n | input | 1 | Control port load strobe, active low |
| in_valid | input | 1 | Input sample pair valid |
| in_left | input | 16 | Left input sample, two's complement |
| in_right | input | 16 | Right input sample, two's complement |
| out_valid | output | 1 | Output sample pair valid |
| out_left | output | 16 | Attenuated left sample |
| out_right | output | 16 | Attenuated right sample |

## Verification
The hardest case to reach from the ports is a frame that is valid only as its last 14 bits. Closely related is a strobe that falls after a partial frame, which must not disturb the bit count for the next frame. The stimulus gets there with a task that shifts an arbitrary number of bits before the strobe. It sends short frames, long frames whose tail is a good command, and good frames after a discarded partial one. Random commands, some with corrupted keys, are interleaved with random sample pairs. The bench tracks the code it expects to be in force and compares every output against it.

// File: rtl/vatt_pkg.sv
package vatt_pkg;
  localparam int SAMPLE_W = 16;
  localparam int CODE_W   = 6;
  localparam int KEY_W    = 8;
  localparam int CMD_W    = KEY_W + CODE_W;
  localparam int FRAC_W   = CODE_W;
  localparam int MULT_W   = FRAC_W + 1;
  localparam logic [KEY_W-1:0] CMD_KEY = 8'h5D;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [MULT_W-1:0] mult_t;

  // Code to linear multiplier in units of 1/64.
  function automatic mult_t code_to_mult(input code_t k);
    mult_t m;
    if (k == '0)
      m = mult_t'(1 << FRAC_W);
    else if (k == '1)
      m = '0;
    else
      m = mult_t'((1 << FRAC_W) - 1) - mult_t'(k);
    return m;
  endfunction
endpackage

// File: rtl/vatt_rst_sync.sv
module vatt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  always_comb chain_n = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_n;
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/vatt_sync.sv
module vatt_sync #(
  parameter int          WIDTH  = 3,
  parameter int          STAGES = 2,
  parameter logic [WIDTH-1:0] IDLE = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_n;
    if (s == 0) begin : g_first
      always_comb stage_n = async_in;
    end else begin : g_rest
      always_comb stage_n = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= IDLE;
      else        stage_q[s] <= stage_n;
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/vatt_cmd_port.sv
module vatt_cmd_port
  import vatt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sclk_s,
  input  logic  sdat_s,
  input  logic  load_s,
  output code_t code_q
);
  localparam int CNT_W = $clog2(CMD_W + 1);

  logic             sclk_d, load_d;
  logic [CMD_W-1:0] shreg_q, shreg_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  code_t            code_n;
  logic             sclk_rise, load_rise, load_fall, frame_full, key_ok;

  always_comb begin
    sclk_rise  = sclk_s & ~sclk_d;
    load_rise  = load_s & ~load_d;
    load_fall  = ~load_s & load_d;
    frame_full = (cnt_q == CNT_W'(CMD_W));
    key_ok     = (shreg_q[KEY_W-1:0] == CMD_KEY);
  end

  // Next state: shift on control clock rise while strobe high, count saturates.
  always_comb begin
    shreg_n = shreg_q;
    cnt_n   = cnt_q;
    code_n  = code_q;
    if (load_rise) begin
      cnt_n = '0;
    end else if (load_s && sclk_rise) begin
      shreg_n = {sdat_s, shreg_q[CMD_W-1:1]};
      if (!frame_full) cnt_n = cnt_q + 1'b1;
    end
    if (load_fall && frame_full && key_ok)
      code_n = shreg_q[CMD_W-1:KEY_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b1;
      load_d  <= 1'b1;
      shreg_q <= '0;
      cnt_q   <= '0;
      code_q  <= '0;
    end else begin
      sclk_d  <= sclk_s;
      load_d  <= load_s;
      shreg_q <= shreg_n;
      cnt_q   <= cnt_n;
      code_q  <= code_n;
    end
  end
endmodule

// File: rtl/vatt_scale.sv
module vatt_scale
  import vatt_pkg::*;
#(
  parameter int DW = SAMPLE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [DW-1:0] sample,
  input  mult_t                mult,
  output logic signed [DW-1:0] q
);
  localparam int PW = DW + MULT_W + 1;

  logic signed [PW-1:0] a_ext, b_ext, prod;
  logic signed [DW-1:0] scaled, q_n;

  always_comb begin
    a_ext  = PW'(sample);
    b_ext  = $signed(PW'(mult));
    prod   = a_ext * b_ext;
    scaled = DW'(prod >>> FRAC_W);
    q_n    = en ? scaled : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_n;
  end
endmodule

// File: rtl/vatt_top.sv
module vatt_top
  import vatt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ctl_clk,
  input  logic                       ctl_data,
  input  logic                       ctl_load_n,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_left,
  input  logic signed [SAMPLE_W-1:0] in_right,
  output logic                       out_valid,
  output logic signed [SAMPLE_W-1:0] out_left,
  output logic signed [SAMPLE_W-1:0] out_right
);
  localparam int NCH = 2;

  logic        rst_sn;
  logic [2:0]  pins_s;
  code_t       code_q;
  mult_t       mult;
  logic        valid_n;
  logic signed [SAMPLE_W-1:0] ch_in  [NCH];
  logic signed [SAMPLE_W-1:0] ch_out [NCH];

  vatt_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  vatt_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .IDLE(3'b101)) u_sync (
    .clk(clk), .rst_n(rst_sn),
    .async_in({ctl_clk, ctl_data, ctl_load_n}),
    .sync_out(pins_s)
  );

  vatt_cmd_port u_cmd (
    .clk(clk), .rst_n(rst_sn),
    .sclk_s(pins_s[2]), .sdat_s(pins_s[1]), .load_s(pins_s[0]),
    .code_q(code_q)
  );

  always_comb begin
    mult      = code_to_mult(code_q);
    ch_in[0]  = in_left;
    ch_in[1]  = in_right;
    valid_n   = in_valid;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    vatt_scale #(.DW(SAMPLE_W)) u_scale (
      .clk(clk), .rst_n(rst_sn), .en(in_valid),
      .sample(ch_in[c]), .mult(mult), .q(ch_out[c])
    );
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) out_valid <= 1'b0;
    else         out_valid <= valid_n;
  end

  assign out_left  = ch_out[0];
  assign out_right = ch_out[1];
endmodule

// File: rtl/vatt_checker.sv
module vatt_checker
  import vatt_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic signed [SAMPLE_W-1:0] in_left,
  input logic signed [SAMPLE_W-1:0] in_right,
  input logic                       out_valid,
  input logic signed [SAMPLE_W-1:0] out_left,
  input logic signed [SAMPLE_W-1:0] out_right,
  input code_t                      code,
  input logic                       load_sync
);
  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_left) && $stable(out_right)));
  assert_unity_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && code == '0) |=>
      (out_left == $past(in_left) && out_right == $past(in_right)));
  assert_mute_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && code == '1) |=> (out_left == '0 && out_right == '0));
  assert_code_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_sync |=> $stable(code));
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_left >= 0) |=> (out_left >= 0 && out_left <= $past(in_left)));
endmodule

bind vatt_top vatt_checker u_vatt_checker (
  .clk(clk), .rst_n(rst_sn), .in_valid(in_valid), .in_left(in_left),
  .in_right(in_right), .out_valid(out_valid), .out_left(out_left),
  .out_right(out_right), .code(code_q), .load_sync(pins_s[0])
);

// File: tb/vatt_top_tb_top.sv
`timescale 1ns/1ps
module vatt_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_clk = 1'b1, ctl_data = 1'b0, ctl_load_n = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] in_left = '0, in_right = '0;
  logic out_valid;
  logic signed [15:0] out_left, out_right;

  int tests = 0;
  int fails = 0;
  int exp_code = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vatt_top dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_clk(ctl_clk), .ctl_data(ctl_data),
    .ctl_load_n(ctl_load_n), .in_valid(in_valid), .in_left(in_left),
    .in_right(in_right), .out_valid(out_valid), .out_left(out_left),
    .out_right(out_right)
  );

  function automatic int mult_of(input int k);
    if (k == 0) return 64;
    if (k == 63) return 0;
    return 63 - k;
  endfunction

  function automatic logic signed [15:0] expect_val(input logic signed [15:0] x, input int k);
    int p;
    p = int'(x) * mult_of(k);
    return 16'(p >>> 6);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Shift n bits of v, LSB first, then pulse the load strobe low.
  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      ctl_data = v[i];
      wait_clk(2);
      ctl_clk = 1'b0;
      wait_clk(4);
      ctl_clk = 1'b1;
      wait_clk(4);
    end
    ctl_load_n = 1'b0;
    wait_clk(8);
    ctl_load_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic send_cmd(input logic [7:0] key, input int code);
    send_bits({18'd0, 6'(code), key}, 14);
    if (key == 8'h5D) exp_code = code;
  endtask

  task automatic push(input logic signed [15:0] l, input logic signed [15:0] r, input string req);
    logic signed [15:0] el, er;
    el = expect_val(l, exp_code);
    er = expect_val(r, exp_code);
    @(negedge clk);
    in_valid = 1'b1; in_left = l; in_right = r;
    @(negedge clk);
    in_valid = 1'b0; in_left = 16'($urandom); in_right = 16'($urandom);
    chk({req, " valid"}, int'(out_valid), 1);
    chk({req, " left"}, int'(out_left), int'(el));
    chk({req, " right"}, int'(out_right), int'(er));
    @(negedge clk);
    chk("R9 valid low", int'(out_valid), 0);
    chk("R9 hold", int'(out_left), int'(el));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ctl_clk = 1'b1; ctl_load_n = 1'b1; in_valid = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    exp_code = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 out_left", int'(out_left), 0);
    chk("R1 out_right", int'(out_right), 0);
    push(16'sd1234, -16'sd4321, "R1 unity");

    send_cmd(8'h5D, 31);
    push(16'sd1000, -16'sd1000, "R2 R5 code31");
    send_cmd(8'h5D, 3);   // reversed bit order would give 48
    push(16'sd6400, 16'sd64, "R2 order");
    send_cmd(8'h5D, 1);
    push(16'sd32767, -16'sd32768, "R5 code1");
    send_cmd(8'h5D, 32);
    push(16'sd32767, -16'sd32768, "R5 code32");
    send_cmd(8'h5D, 62);
    push(16'sd32767, -16'sd32768, "R5 code62");
    push(-16'sd1, 16'sd63, "R8 code62 a");
    push(-16'sd64, -16'sd65, "R8 code62 b");
    send_cmd(8'h5D, 1);
    push(-16'sd1, 16'sd1, "R8 code1");
    send_cmd(8'h5D, 63);
    push(16'sd32767, -16'sd32768, "R7 mute");
    send_cmd(8'h5D, 0);
    push(-16'sd32768, 16'sd32767, "R6 unity");
    push(16'sd5, -16'sd7, "R10 independent");

    send_cmd(8'h5D, 10);
    send_cmd(8'h5C, 40);
    push(16'sd6400, 16'sd6400, "R3 bad key 5C");
    send_cmd(8'hDD, 40);
    push(16'sd6400, -16'sd6400, "R3 bad key DD");

    send_bits({18'd0, 6'd20, 8'h5D}, 13);
    push(16'sd6400, 16'sd100, "R4 short frame");
    send_bits(32'h3F, 6);
    send_cmd(8'h5D, 20);
    push(16'sd6400, 16'sd100, "R4 after partial");
    send_bits({12'd0, 6'd45, 8'h5D, 6'b101101}, 20);
    exp_code = 45;
    push(16'sd6400, -16'sd300, "R4 long frame");

    for (int it = 0; it < 300; it++) begin
      if (($urandom % 8) == 0) begin
        if (($urandom % 4) == 0) send_cmd(8'($urandom), int'($urandom % 64));
        else send_cmd(8'h5D, int'($urandom % 64));
      end
      push(16'($urandom), 16'($urandom), "R5 R10 random");
    end

    send_cmd(8'h5D, 50);
    do_reset();
    push(16'sd3000, -16'sd3000, "R11 reset unity");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule